// File: doc/BRIEF.md
# Latch-Bank Output Expander

This block turns a small set of shared data pins plus one strobe pin per external latch into a much larger set of output-only virtual pins. Each external latch captures the shared data lines when its own strobe fires. Each virtual output therefore lives in one latch group, at one line position within that group.

The block holds a shadow copy of every virtual output. A host request carries one virtual index and one bit value. The block updates that single shadow bit and drives the whole group's shadow contents onto the shared data lines. It then waits a programmed setup time and pulses the strobe of that group's latch for a programmed width. Both times are given in nanoseconds. Each is capped at 5000 ns and turned into whole clock cycles, with at least one cycle.

The request side is a valid/ready stream. The block is ready only while it is idle. A request is taken in the cycle where `req_valid` and `req_ready` are both high. While `req_ready` is low the host must hold `req_valid`, `req_index` and `req_value` steady. No request is lost and none is taken twice. Setting a virtual pin as an output with a value is the same operation as a write, because every virtual pin is always an output.

Top module: `lxp_ctrl`

## Requirements
- R1: The block exposes TOTAL = NUM_LATCH × LINES virtual outputs, indexed 0 to TOTAL−1. `req_index` is one bit wider than needed, so that indices at or above TOTAL can be presented.
- R2: An accepted in-range request targets group `req_index / LINES`. Only that group's strobe pin pulses.
- R3: An accepted in-range write changes only shadow bit `req_index`. Every other shadow bit keeps its value.
- R4: One cycle after acceptance, `data_out[i]` equals shadow bit (group × LINES + i) for every line i, with the new bit included. The lines hold that value until the next accepted in-range write.
- R5: After acceptance the strobe stays inactive for exactly SETUP_C cycles, with the data lines stable. SETUP_C = ceil(min(SETUP_NS, 5000) / CLK_PERIOD_NS), and at least 1.
- R6: The strobe is then active for exactly PULSE_C cycles, then returns inactive. PULSE_C is computed from PULSE_NS with the same rule. At most one strobe is active at any time.
- R7: A programmed duration above 5000 ns behaves exactly like 5000 ns.
- R8: During and after reset, the shadow and `data_out` are all zero, every strobe pin sits at its inactive level, `req_err` is 0 and `req_ready` is 1.
- R9: `req_ready` is 1 only while idle. It falls in the cycle after an in-range request is accepted and rises again in the cycle after the strobe returns inactive.
- R10: An accepted request with `req_index` ≥ TOTAL changes neither the shadow nor `data_out`, and fires no strobe. `req_err` is 1 for exactly the following cycle and `req_ready` stays 1.
- R11: Bit g of POL_MASK selects the polarity of strobe g. A 0 gives an idle-low, active-high pin. A 1 gives an idle-high, active-low pin.
- R12: A programmed duration of 0 ns still gives one cycle of setup or pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, period CLK_PERIOD_NS |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_index | input | IDX_W | Virtual output index, $clog2(TOTAL)+1 bits |
| req_value | input | 1 | Value for the addressed virtual output |
| req_err | output | 1 | One-cycle flag for an out-of-range request |
| data_out | output | LINES | Shared latch data lines |
| latch_clk | output | NUM_LATCH | Per-latch strobe pins, polarity set by POL_MASK |

## Verification
A corrupted shadow bit stays hidden until its group is presented again. It then shows on `data_out` one cycle after the next accepted write to that group. The bench therefore writes several bits within one group and compares whole groups. A miscounted setup or pulse timer shows within the same transaction as a strobe that starts or ends one cycle off. A decode error shows as the wrong strobe pin, or a wrong level on an idle pin. A sequencer stuck outside idle shows as `req_ready` staying low from the first cycle it should have risen.

// File: rtl/lxp_pkg.sv
package lxp_pkg;

  localparam int unsigned LXP_CAP_NS = 5000;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_PULSE = 2'd2
  } lxp_phase_e;

  // nanoseconds -> cycles: clamp, round up, never below one cycle
  function automatic int unsigned lxp_cycles(input int unsigned ns,
                                             input int unsigned period_ns);
    int unsigned lim;
    int unsigned c;
    lim = (ns > LXP_CAP_NS) ? LXP_CAP_NS : ns;
    c   = (lim + period_ns - 1) / period_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

endpackage

// File: rtl/lxp_timer.sv
module lxp_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/lxp_shadow.sv
module lxp_shadow #(
  parameter int NUM_LATCH = 4,
  parameter int LINES     = 8,
  parameter int IDX_W     = 6,
  parameter int GRP_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_val,
  input  logic [GRP_W-1:0] rd_grp,
  output logic [LINES-1:0] grp_bits
);
  localparam int TOTAL = NUM_LATCH * LINES;

  logic [TOTAL-1:0] sh_q, sh_d;
  logic [LINES-1:0] grp_arr [NUM_LATCH];

  always_comb begin
    sh_d = sh_q;
    for (int b = 0; b < TOTAL; b++) begin
      if (wr_en && (wr_idx == IDX_W'(b))) sh_d[b] = wr_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  // group view of the next-state shadow so the new bit is presented at once
  for (genvar g = 0; g < NUM_LATCH; g++) begin : g_view
    assign grp_arr[g] = sh_d[g*LINES +: LINES];
  end

  assign grp_bits = grp_arr[rd_grp];
endmodule

// File: rtl/lxp_strobe.sv
module lxp_strobe #(
  parameter int                   NUM_LATCH = 4,
  parameter int                   GRP_W     = 2,
  parameter logic [NUM_LATCH-1:0] POL_MASK  = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fire,
  input  logic                 clear,
  input  logic [GRP_W-1:0]     grp,
  output logic [NUM_LATCH-1:0] pins
);
  logic [NUM_LATCH-1:0] act_q;

  for (genvar g = 0; g < NUM_LATCH; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     act_q[g] <= 1'b0;
      else if (fire)  act_q[g] <= (grp == GRP_W'(g));
      else if (clear) act_q[g] <= 1'b0;
    end
    assign pins[g] = act_q[g] ^ POL_MASK[g];
  end
endmodule

// File: rtl/lxp_ctrl.sv
module lxp_ctrl #(
  parameter int                   NUM_LATCH     = 4,
  parameter int                   LINES         = 8,
  parameter int                   CLK_PERIOD_NS = 5,
  parameter int                   SETUP_NS      = 12,
  parameter int                   PULSE_NS      = 10,
  parameter logic [NUM_LATCH-1:0] POL_MASK      = '0,
  localparam int                  TOTAL         = NUM_LATCH * LINES,
  localparam int                  IDX_W         = $clog2(TOTAL) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [IDX_W-1:0]     req_index,
  input  logic                 req_value,
  output logic                 req_err,
  output logic [LINES-1:0]     data_out,
  output logic [NUM_LATCH-1:0] latch_clk
);
  import lxp_pkg::*;

  localparam int GRP_W   = (NUM_LATCH > 1) ? $clog2(NUM_LATCH) : 1;
  localparam int SETUP_C = int'(lxp_cycles(SETUP_NS, CLK_PERIOD_NS));
  localparam int PULSE_C = int'(lxp_cycles(PULSE_NS, CLK_PERIOD_NS));
  localparam int MAX_C   = (SETUP_C > PULSE_C) ? SETUP_C : PULSE_C;
  localparam int CNT_W   = $clog2(MAX_C) + 1;

  lxp_phase_e       ph_q;
  logic [GRP_W-1:0] grp_req, grp_q;
  logic [LINES-1:0] grp_bits;
  logic             accept, in_range, wr_en;
  logic             tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  logic             fire, clear;
  logic             err_q;
  logic [LINES-1:0] data_q;

  assign req_ready = (ph_q == PH_IDLE);
  assign accept    = req_valid && req_ready;
  assign in_range  = (req_index < IDX_W'(TOTAL));
  assign wr_en     = accept && in_range;
  assign grp_req   = GRP_W'(req_index / IDX_W'(LINES));

  assign fire  = (ph_q == PH_SETUP) && tmr_zero;
  assign clear = (ph_q == PH_PULSE) && tmr_zero;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (wr_en) begin
      tmr_load = 1'b1;
      tmr_val  = CNT_W'(SETUP_C - 1);
    end else if (fire) begin
      tmr_load = 1'b1;
      tmr_val  = CNT_W'(PULSE_C - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      grp_q  <= '0;
      data_q <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= accept && !in_range;
      unique case (ph_q)
        PH_IDLE: if (wr_en) begin
          ph_q   <= PH_SETUP;
          grp_q  <= grp_req;
          data_q <= grp_bits;
        end
        PH_SETUP: if (tmr_zero) ph_q <= PH_PULSE;
        PH_PULSE: if (tmr_zero) ph_q <= PH_IDLE;
        default:  ph_q <= PH_IDLE;
      endcase
    end
  end

  lxp_shadow #(
    .NUM_LATCH(NUM_LATCH), .LINES(LINES), .IDX_W(IDX_W), .GRP_W(GRP_W)
  ) u_shadow (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(req_index),
    .wr_val(req_value), .rd_grp(grp_req), .grp_bits(grp_bits)
  );

  lxp_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  lxp_strobe #(
    .NUM_LATCH(NUM_LATCH), .GRP_W(GRP_W), .POL_MASK(POL_MASK)
  ) u_strobe (
    .clk(clk), .rst_n(rst_n), .fire(fire), .clear(clear),
    .grp(grp_q), .pins(latch_clk)
  );

  assign data_out = data_q;
  assign req_err  = err_q;
endmodule

// File: rtl/lxp_ctrl_chk.sv
module lxp_ctrl_chk #(
  parameter int                   NUM_LATCH = 4,
  parameter int                   LINES     = 8,
  parameter logic [NUM_LATCH-1:0] POL_MASK  = '0,
  localparam int                  TOTAL     = NUM_LATCH * LINES,
  localparam int                  IDX_W     = $clog2(TOTAL) + 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic [IDX_W-1:0]     req_index,
  input logic                 req_err,
  input logic [LINES-1:0]     data_out,
  input logic [NUM_LATCH-1:0] latch_clk
);
  logic [NUM_LATCH-1:0] act;
  logic                 any_act;
  assign act     = latch_clk ^ POL_MASK;
  assign any_act = |act;

  p_single_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act));

  p_busy_while_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    any_act |-> !req_ready);

  p_ready_after_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(any_act) |-> req_ready);

  p_take_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_index < IDX_W'(TOTAL)) |=> !req_ready);

  p_reject_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_index >= IDX_W'(TOTAL))
      |=> (req_err && req_ready && $stable(data_out) && !any_act));

  p_lines_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !$past(req_ready)) |-> $stable(data_out));
endmodule

bind lxp_ctrl lxp_ctrl_chk #(
  .NUM_LATCH(NUM_LATCH), .LINES(LINES), .POL_MASK(POL_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_index(req_index), .req_err(req_err), .data_out(data_out),
  .latch_clk(latch_clk)
);

// File: tb/test_lxp_ctrl.sv
`timescale 1ns/100ps
module test_lxp_ctrl;
  localparam int NL = 4, LN = 8, PER = 5;
  localparam int TOTAL = NL * LN, IW = $clog2(TOTAL) + 1;
  localparam logic [NL-1:0] MASK = 4'b0101;
  localparam int SNS = 12, PNS = 10;
  localparam int BNL = 2, BLN = 4, BIW = $clog2(BNL*BLN) + 1;

  function automatic int cyc(input int ns);
    int c;
    c = (ns > 5000) ? 5000 : ns;
    c = (c + PER - 1) / PER;
    if (c < 1) c = 1;
    return c;
  endfunction

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic a_valid = 1'b0, a_value = 1'b0, a_ready, a_err;
  logic [IW-1:0] a_index = '0;
  logic [LN-1:0] a_data;
  logic [NL-1:0] a_clk;

  logic b_valid = 1'b0, b_ready, b_err;
  logic [BIW-1:0] b_index = '0;
  logic [BLN-1:0] b_data;
  logic [BNL-1:0] b_clk;

  lxp_ctrl #(.NUM_LATCH(NL), .LINES(LN), .CLK_PERIOD_NS(PER), .SETUP_NS(SNS),
             .PULSE_NS(PNS), .POL_MASK(MASK)) i_lxp_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(a_valid), .req_ready(a_ready),
    .req_index(a_index), .req_value(a_value), .req_err(a_err),
    .data_out(a_data), .latch_clk(a_clk));

  // long setup (clamped), zero pulse (one cycle)
  lxp_ctrl #(.NUM_LATCH(BNL), .LINES(BLN), .CLK_PERIOD_NS(PER), .SETUP_NS(9000),
             .PULSE_NS(0), .POL_MASK(2'b00)) i_lxp_ctrl_b (
    .clk(clk), .rst_n(rst_n), .req_valid(b_valid), .req_ready(b_ready),
    .req_index(b_index), .req_value(1'b1), .req_err(b_err),
    .data_out(b_data), .latch_clk(b_clk));

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference for instance A
  logic [TOTAL-1:0] m_sh;
  logic [LN-1:0]    m_data;
  logic [NL-1:0]    m_act;
  int m_ph, m_cnt, m_grp;
  bit m_err;
  bit cmp_en = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sh = '0; m_data = '0; m_act = '0; m_ph = 0; m_cnt = 0; m_err = 0; m_grp = 0;
    end else begin
      m_err = 0;
      case (m_ph)
        0: if (a_valid) begin
          if (int'(a_index) < TOTAL) begin
            m_sh[a_index] = a_value;
            m_grp = int'(a_index) / LN;
            for (int i = 0; i < LN; i++) m_data[i] = m_sh[m_grp*LN + i];
            m_ph = 1; m_cnt = cyc(SNS);
          end else m_err = 1;
        end
        1: begin
          m_cnt--;
          if (m_cnt == 0) begin m_ph = 2; m_cnt = cyc(PNS); m_act[m_grp] = 1'b1; end
        end
        default: begin
          m_cnt--;
          if (m_cnt == 0) begin m_ph = 0; m_act = '0; end
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_en && !finished) begin
      chk("R3 R4 data lines", a_data, m_data);
      chk("R2 R5 R6 R11 strobes", a_clk, m_act ^ MASK);
      chk("R9 ready", a_ready, (m_ph == 0));
      chk("R10 err", a_err, m_err);
    end
  end

  task automatic send(input int idx, input logic val);
    @(negedge clk);
    a_valid = 1'b1; a_index = IW'(idx); a_value = val;
    while (!a_ready) @(negedge clk);
    @(negedge clk);
    a_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (!a_ready) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(PER * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int s, p;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R8 reset state
    chk("R8 data", a_data, 0);
    chk("R8 strobe idle levels", a_clk, MASK);
    chk("R8 ready", a_ready, 1);
    chk("R8 err", a_err, 0);
    chk("R8 B strobes", b_clk, 0);
    cmp_en = 1;

    // R3 R4: two bits in group 1, whole group presented
    send(10, 1'b1); wait_idle();
    send(13, 1'b1); wait_idle();
    chk("R3 R4 group1 after two writes", a_data, 8'h24);
    send(10, 1'b0); wait_idle();
    chk("R3 group1 after clearing bit 10", a_data, 8'h20);

    // R5 R6 R2 R11: timing and strobe pin of group 2
    send(17, 1'b1);
    s = 0; while (a_clk == MASK && s < 50) begin s++; @(negedge clk); end
    chk("R5 setup cycles", s, cyc(SNS));
    chk("R2 R11 active pin pattern", a_clk, 4'b0001);
    p = 0; while (a_clk != MASK && p < 50) begin p++; @(negedge clk); end
    chk("R6 pulse cycles", p, cyc(PNS));
    chk("R4 group2 lines", a_data, 8'h02);

    // R1: last index, group 3
    send(TOTAL - 1, 1'b1);
    while (a_clk == MASK) @(negedge clk);
    chk("R1 R2 R11 last index strobe", a_clk, 4'b1101);
    wait_idle();
    chk("R1 last index line", a_data, 8'h80);

    // R10: out of range, lines and shadow untouched
    send(TOTAL + 8, 1'b1);
    chk("R10 ready stays", a_ready, 1);
    chk("R10 lines unchanged", a_data, 8'h80);
    send(24, 1'b0); wait_idle();
    chk("R10 shadow unchanged", a_data, 8'h80 & 8'h7F | 8'h80);

    // R9: back-to-back requests, random mix
    for (int k = 0; k < 60; k++) send(int'($urandom_range(0, TOTAL + 7)), 1'($urandom));
    wait_idle();

    // R7 R12: clamped setup, minimum pulse on instance B
    @(negedge clk);
    b_valid = 1'b1; b_index = BIW'(5);
    @(negedge clk);
    b_valid = 1'b0;
    s = 0; while (b_clk == 2'b00 && s < 3000) begin s++; @(negedge clk); end
    chk("R7 clamped setup cycles", s, 1000);
    chk("R2 B group1 strobe", b_clk, 2'b10);
    chk("R4 B lines", b_data, 4'b0010);
    p = 0; while (b_clk != 2'b00 && p < 50) begin p++; @(negedge clk); end
    chk("R12 zero pulse gives one cycle", p, 1);
    chk("R9 B ready after pulse", b_ready, 1);
    chk("R10 B no error", b_err, 0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule